// File: doc/BRIEF.md
# Saturating 64-bit Add/Subtract Unit

This unit performs one saturating integer operation per clock on two 64-bit operands. It supports signed and unsigned add, signed and unsigned subtract, and two accumulate forms with mixed signedness. In the first accumulate form an unsigned operand is added into a signed accumulator. In the second a signed operand is added into an unsigned accumulator. Each operation is computed exactly in a widened datapath and then clamped to the range of the destination type. A clamp raises a one-cycle saturation pulse beside the result. It also sets a sticky cumulative saturation bit, which holds until a synchronous clear.

The operand side is a valid strobe with no ready. The unit has no back-pressure: it accepts an operation on every cycle in which `vld_i` is high. The result side is a registered valid, `res_vld_o`. The sticky bit and the clear are plain status and control pins.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcode 0 (signed add): the result is the two's-complement sum of `a_i` and `b_i`, clamped to [-2^63, 2^63-1]. `sat_o` is high exactly when a clamp happens.
- R2: Opcode 1 (unsigned add): the result is the sum of `a_i` and `b_i`. When that sum exceeds 2^64-1 the result is all ones and `sat_o` is set.
- R3: Opcode 2 (signed subtract): the result is `a_i - b_i` taken as signed values, clamped to [-2^63, 2^63-1]. `sat_o` flags a clamp.
- R4: Opcode 3 (unsigned subtract): the result is `a_i - b_i`. When `a_i < b_i` the result is zero and `sat_o` is set.
- R5: Opcode 4: signed `a_i` plus unsigned `b_i` gives a signed result. A sum above 2^63-1 is clamped to 2^63-1 with `sat_o` set. This includes a large `b_i` with `a_i` zero or positive. A negative `a_i` plus a large `b_i` that lands in range is returned exactly.
- R6: Opcode 5: unsigned `a_i` plus signed `b_i` gives an unsigned result. A negative true sum gives zero, and a sum above 2^64-1 gives all ones, each with `sat_o` set. A large `a_i` plus a negative `b_i` is returned without saturation.
- R7: Opcodes 6 and 7 return `a_i` unchanged, with `sat_o` low and the sticky bit untouched.
- R8: An operation accepted at a rising edge with `vld_i` high shows on `res_o`, `sat_o` and `res_vld_o` right after that edge. On a cycle without `vld_i`, `res_vld_o` and `sat_o` go low and `res_o` holds its value.
- R9: `sticky_o` is set by every accepted operation that saturates. It then stays set through later operations that do not saturate.
- R10: `clr_i` high at an edge clears `sticky_o`. This holds even when a saturating operation is accepted at the same edge.
- R11: After reset (`rst_ni` low), `res_o` is zero and `res_vld_o`, `sat_o` and `sticky_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operation valid strobe |
| op_i | input | 3 | Operation code |
| a_i | input | 64 | First operand (accumulator for opcodes 4 and 5) |
| b_i | input | 64 | Second operand |
| clr_i | input | 1 | Synchronous clear of the sticky bit |
| res_vld_o | output | 1 | Result valid, one cycle after acceptance |
| res_o | output | 64 | Saturated result |
| sat_o | output | 1 | Saturation occurred on the reported operation |
| sticky_o | output | 1 | Cumulative saturation status bit |

## Verification
Every result is due one register stage after acceptance. `res_o`, `sat_o`, `res_vld_o` and the sticky bit all change at the edge that samples `vld_i`. The bench therefore drives operands at a falling edge and drops `vld_i` at the next falling edge. It compares all outputs at that moment, which is half a period after the capturing edge. The hold checks compare the outputs at the falling edge after an idle cycle. The clear checks look at `sticky_o` at the falling edge that follows the edge where `clr_i` was sampled.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;
  typedef enum logic [2:0] {
    OP_SADD = 3'd0,
    OP_UADD = 3'd1,
    OP_SSUB = 3'd2,
    OP_USUB = 3'd3,
    OP_SACC = 3'd4,  // signed acc += unsigned
    OP_UACC = 3'd5,  // unsigned acc += signed
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } sat_op_e;

  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic sub;
    logic d_sgn;
    logic pass;
  } sat_ctl_t;
endpackage

// File: rtl/sat_op_decode.sv
module sat_op_decode
  import sat_arith_pkg::*;
(
  input  logic [2:0] op_i,
  output sat_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (sat_op_e'(op_i))
      OP_SADD: begin ctl_o.a_sgn = 1'b1; ctl_o.b_sgn = 1'b1; ctl_o.d_sgn = 1'b1; end
      OP_UADD: ;
      OP_SSUB: begin ctl_o.a_sgn = 1'b1; ctl_o.b_sgn = 1'b1; ctl_o.d_sgn = 1'b1; ctl_o.sub = 1'b1; end
      OP_USUB: ctl_o.sub = 1'b1;
      OP_SACC: begin ctl_o.a_sgn = 1'b1; ctl_o.d_sgn = 1'b1; end
      OP_UACC: ctl_o.b_sgn = 1'b1;
      default: ctl_o.pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/sat_wide_addsub.sv
module sat_wide_addsub #(
  parameter int W  = 64,
  localparam int EW = W + 2
) (
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic                 a_sgn_i,
  input  logic                 b_sgn_i,
  input  logic                 sub_i,
  output logic signed [EW-1:0] sum_o
);
  logic [1:0][W-1:0] opd;
  logic [1:0]        sgn;
  logic signed [EW-1:0] ext [2];

  assign opd = {b_i, a_i};
  assign sgn = {b_sgn_i, a_sgn_i};

  for (genvar i = 0; i < 2; i++) begin : g_ext
    assign ext[i] = sgn[i] ? {{2{opd[i][W-1]}}, opd[i]} : {2'b00, opd[i]};
  end

  assign sum_o = sub_i ? (ext[0] - ext[1]) : (ext[0] + ext[1]);
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int W  = 64,
  localparam int EW = W + 2
) (
  input  logic signed [EW-1:0] val_i,
  input  logic                 d_sgn_i,
  output logic [W-1:0]         res_o,
  output logic                 sat_o
);
  logic signed [EW-1:0] hi_lim, lo_lim;

  always_comb begin
    if (d_sgn_i) begin
      hi_lim = {3'b000, {(W-1){1'b1}}};
      lo_lim = {3'b111, {(W-1){1'b0}}};
    end else begin
      hi_lim = {2'b00, {W{1'b1}}};
      lo_lim = '0;
    end
    if (val_i > hi_lim) begin
      res_o = hi_lim[W-1:0];
      sat_o = 1'b1;
    end else if (val_i < lo_lim) begin
      res_o = lo_lim[W-1:0];
      sat_o = 1'b1;
    end else begin
      res_o = val_i[W-1:0];
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/sat_sticky_flag.sv
module sat_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_arith_pkg::*;
#(
  parameter int W = 64,
  localparam int EW = W + 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         clr_i,
  output logic         res_vld_o,
  output logic [W-1:0] res_o,
  output logic         sat_o,
  output logic         sticky_o
);
  sat_ctl_t             ctl;
  logic signed [EW-1:0] wide;
  logic [W-1:0]         clamped;
  logic                 clamp_hit;
  logic [W-1:0]         res_d;
  logic                 sat_d;

  sat_op_decode u_dec (.op_i(op_i), .ctl_o(ctl));

  sat_wide_addsub #(.W(W)) u_add (
    .a_i(a_i), .b_i(b_i), .a_sgn_i(ctl.a_sgn), .b_sgn_i(ctl.b_sgn),
    .sub_i(ctl.sub), .sum_o(wide)
  );

  sat_clamp #(.W(W)) u_clamp (
    .val_i(wide), .d_sgn_i(ctl.d_sgn), .res_o(clamped), .sat_o(clamp_hit)
  );

  always_comb begin
    res_d = ctl.pass ? a_i : clamped;
    sat_d = vld_i & ~ctl.pass & clamp_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o <= 1'b0;
      res_o     <= '0;
      sat_o     <= 1'b0;
    end else begin
      res_vld_o <= vld_i;
      sat_o     <= sat_d;
      if (vld_i) res_o <= res_d;
    end
  end

  sat_sticky_flag u_sticky (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(sat_d), .clr_i(clr_i), .flag_o(sticky_o)
  );
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         vld_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         clr_i,
  input logic         res_vld_o,
  input logic [W-1:0] res_o,
  input logic         sat_o,
  input logic         sticky_o
);
  // R2
  uadd_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_i == 3'd1 && a_i > ~b_i) |=> (res_o == {W{1'b1}} && sat_o));
  // R4
  usub_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_i == 3'd3 && a_i < b_i) |=> (res_o == '0 && sat_o));
  // R7
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_i[2:1] == 2'b11) |=> (res_o == $past(a_i) && !sat_o));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(res_o) && !res_vld_o && !sat_o));
  // R9
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_o && !clr_i) |=> sticky_o);
  // R9
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i) |=> (!sat_o || sticky_o));
  // R10
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sticky_o);
endmodule

bind sat_arith_unit sat_arith_chk #(.W(W)) chk_i (.*);

// File: tb/sat_arith_unit_tb.sv
`timescale 1ns/1ps
module sat_arith_unit_tb_top;
  localparam int W = 64;
  localparam logic [63:0] SMAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [2:0] op = '0;
  logic [63:0] a = '0, b = '0;
  logic clr = 1'b0;
  logic res_vld, sat, sticky;
  logic [63:0] res;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sat_arith_unit #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .op_i(op), .a_i(a), .b_i(b),
    .clr_i(clr), .res_vld_o(res_vld), .res_o(res), .sat_o(sat), .sticky_o(sticky)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one accepted op, then check result, pulse and valid.
  task automatic run_op(input string req, input logic [2:0] o, input logic [63:0] x,
                        input logic [63:0] y, input logic [63:0] exp_r, input logic exp_s);
    @(negedge clk);
    op = o; a = x; b = y; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check({req, " result"}, res, exp_r);
    check({req, " sat"}, {63'd0, sat}, {63'd0, exp_s});
    check({req, " valid"}, {63'd0, res_vld}, 64'd1);
  endtask

  task automatic t_reset;
    check("R11 res", res, '0);
    check("R11 valid", {63'd0, res_vld}, 0);
    check("R11 sat", {63'd0, sat}, 0);
    check("R11 sticky", {63'd0, sticky}, 0);
  endtask

  task automatic t_sadd;
    run_op("R1 plain", 3'd0, 64'd5, -64'sd7, -64'sd2, 0);
    check("R9 no set", {63'd0, sticky}, 0);
    run_op("R1 pos ovf", 3'd0, SMAX, 64'd1, SMAX, 1);
    run_op("R1 neg ovf", 3'd0, SMIN, -64'sd1, SMIN, 1);
  endtask

  task automatic t_uadd;
    run_op("R2 plain", 3'd1, 64'd100, 64'd23, 64'd123, 0);
    run_op("R2 ovf", 3'd1, ONES - 1, 64'd5, ONES, 1);
  endtask

  task automatic t_ssub;
    run_op("R3 plain", 3'd2, -64'sd3, 64'd4, -64'sd7, 0);
    run_op("R3 neg ovf", 3'd2, SMIN, 64'd1, SMIN, 1);
    run_op("R3 pos ovf", 3'd2, SMAX, -64'sd1, SMAX, 1);
  endtask

  task automatic t_usub;
    run_op("R4 plain", 3'd3, 64'd9, 64'd9, 64'd0, 0);
    run_op("R4 floor", 3'd3, 64'd3, 64'd4, 64'd0, 1);
  endtask

  task automatic t_sacc;
    run_op("R5 big u pos a", 3'd4, 64'd0, SMIN, SMAX, 1);
    run_op("R5 big u neg a", 3'd4, -64'sd10, SMIN, SMAX - 9, 0);
    run_op("R5 big u neg a ovf", 3'd4, -64'sd1, ONES, SMAX, 1);
    run_op("R5 small u ovf", 3'd4, SMAX - 1, 64'd2, SMAX, 1);
    run_op("R5 in range", 3'd4, -64'sd20, 64'd5, -64'sd15, 0);
  endtask

  task automatic t_uacc;
    run_op("R6 neg floor", 3'd5, 64'd3, -64'sd4, 64'd0, 1);
    run_op("R6 big a neg b", 3'd5, ONES, SMIN, SMAX, 0);
    run_op("R6 top", 3'd5, ONES, 64'd1, ONES, 1);
    run_op("R6 in range", 3'd5, 64'd10, -64'sd3, 64'd7, 0);
  endtask

  task automatic t_unused;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    run_op("R7 op6", 3'd6, 64'hDEAD_BEEF_0000_0001, ONES, 64'hDEAD_BEEF_0000_0001, 0);
    run_op("R7 op7", 3'd7, SMAX, 64'd1, SMAX, 0);
    check("R7 sticky untouched", {63'd0, sticky}, 0);
  endtask

  task automatic t_hold;
    run_op("R8 load", 3'd1, 64'd1, 64'd2, 64'd3, 0);
    @(negedge clk);
    op = 3'd1; a = ONES; b = ONES;
    @(negedge clk);
    check("R8 hold res", res, 64'd3);
    check("R8 idle valid", {63'd0, res_vld}, 0);
    check("R8 idle sat", {63'd0, sat}, 0);
  endtask

  task automatic t_sticky;
    run_op("R9 set", 3'd3, 64'd0, 64'd1, 64'd0, 1);
    check("R9 set", {63'd0, sticky}, 1);
    run_op("R9 keep op", 3'd0, 64'd1, 64'd1, 64'd2, 0);
    check("R9 kept", {63'd0, sticky}, 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R10 clear", {63'd0, sticky}, 0);
    @(negedge clk);
    op = 3'd1; a = ONES; b = ONES; vld = 1'b1; clr = 1'b1;
    @(negedge clk);
    vld = 1'b0; clr = 1'b0;
    check("R10 clr over set sat", {63'd0, sat}, 1);
    check("R10 clr over set sticky", {63'd0, sticky}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sadd();
    t_uadd();
    t_ssub();
    t_usub();
    t_sacc();
    t_uacc();
    t_unused();
    t_hold();
    t_sticky();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule